// File: doc/BRIEF.md
# Multi-Phase Instruction Sequencer for an 8-bit Core

This block is the control sequencer of a small 8-bit processor. It owns the program counter, the stack pointer, eight byte registers (the accumulator, the flag byte and three register pairs) and a 16-bit address index. Every instruction moves through four phases in a fixed order: fetch, decode, a stall, then execute. Each operand byte is read in an extra read-at-PC state, and that state is always followed by a stall. A data load or store starts with a one-cycle address-setup state.

The block decodes only a small set of opcodes. It handles a no-op, absolute and relative jumps (each either always taken or conditional on the zero or carry flag), loading an immediate byte into a register, and moving the accumulator to or from a 16-bit immediate address. Any other opcode behaves as a no-op and raises a flag for one cycle. A free-running cycle counter lets a test environment measure what each instruction costs.

The memory port is byte wide and has a fixed latency. The address and strobes are driven from the current state. Read data must be valid combinationally in the same cycle as `mem_rd`. A write happens in the cycle where `mem_wr` is high. The port has no valid/ready handshake, so memory cannot apply back-pressure.

Top module: `cpu_seq_top`

## Requirements
- R1: After reset the registers hold A=0x01, F=0xB0, B=0x00, C=0x13, D=0x00, E=0xD8, H=0x01, L=0x4D, SP=0xFFFE, PC=0x0100, and the cycle counter is 0. The first cycle after reset is a fetch at PC.
- R2: Every instruction begins with fetch (reads the byte at PC), decode (PC+1), stall and execute. Opcode 0x00 is a no-op that takes exactly 4 cycles.
- R3: Each operand byte costs 4 cycles: a read at PC that also increments PC, a stall, another stall and execute. Opcodes 0x06, 0x0E, 0x16, 0x1E, 0x26, 0x2E and 0x3E load the next byte into B, C, D, E, H, L and A respectively, in 8 cycles.
- R4: Absolute jump opcodes 0xC3 (always), 0xC2 (Z clear), 0xCA (Z set), 0xD2 (C clear) and 0xDA (C set) read the low target byte first, then the high byte. They take 12 cycles when not taken and 16 when taken, with PC at the target only when taken.
- R5: Relative jump opcodes 0x18 (always), 0x20 (Z clear), 0x28 (Z set), 0x30 (C clear) and 0x38 (C set) read one signed offset. When taken, the offset is added to the address that follows the offset byte. They take 8 cycles when not taken and 12 when taken.
- R6: Conditions use F bit 7 as Z and F bit 4 as C. A taken jump costs exactly 4 cycles more than the same jump not taken.
- R7: Opcode 0xFA reads a low then a high address byte. A one-cycle setup state follows, then a read at that 16-bit address. The byte read lands in A, and the whole instruction takes 16 cycles.
- R8: Opcode 0xEA reads a low then a high address byte and performs exactly one write of A to that address, preceded by a one-cycle setup state. The instruction takes 16 cycles.
- R9: Any opcode not listed above takes 4 cycles and changes no register other than PC (+1). `illegal_op` is high for exactly one cycle during it and never during a listed opcode.
- R10: `cycle_cnt` increases by one on every clock after reset.
- R11: `mem_rd` and `mem_wr` are never high together. Reads are taken combinationally in the cycle `mem_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe, data sampled this cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the `mem_rd` cycle |
| op_fetch | output | 1 | High in the fetch phase of each instruction |
| illegal_op | output | 1 | One-cycle pulse on an unrecognised opcode |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| reg_af | output | 16 | Accumulator (high) and flag byte (low) |
| reg_bc | output | 16 | B (high) and C (low) |
| reg_de | output | 16 | D (high) and E (low) |
| reg_hl | output | 16 | H (high) and L (low) |
| cycle_cnt | output | 32 | Free-running cycle counter |

## Verification
The hardest behaviour to reach from the ports is the not-taken side of a conditional jump. The block has no flag-changing instruction, so the flag byte keeps its reset value with both Z and C set. The stimulus therefore uses the clear-flag forms for the not-taken cases and the set-flag forms for the taken ones. Each cycle cost is measured between consecutive fetch pulses. A relative jump with offset 0x80 exercises the negative sign extension.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_STALL, ST_EXEC,
    ST_RDPC, ST_RDPC_STALL, ST_MOVE_LD, ST_MOVE_ST,
    ST_MEM_LD, ST_MEM_ST, ST_PENALTY
  } seq_state_e;

  typedef enum logic [2:0] {
    OPC_NOP, OPC_JP, OPC_JR, OPC_LDI, OPC_LDA, OPC_STA, OPC_BAD
  } op_class_e;

  typedef enum logic [2:0] {
    CC_ALWAYS, CC_NZ, CC_Z, CC_NC, CC_C
  } cond_e;

  typedef struct packed {
    op_class_e  cls;
    cond_e      cc;
    logic [2:0] dst;
  } op_info_t;

  // register file slots; codes 0-5 and 7 match the immediate-load field
  localparam int unsigned RIDX_B = 0;
  localparam int unsigned RIDX_C = 1;
  localparam int unsigned RIDX_D = 2;
  localparam int unsigned RIDX_E = 3;
  localparam int unsigned RIDX_H = 4;
  localparam int unsigned RIDX_L = 5;
  localparam int unsigned RIDX_F = 6;
  localparam int unsigned RIDX_A = 7;

  localparam int unsigned FLAG_Z_BIT = 7;
  localparam int unsigned FLAG_C_BIT = 4;

  function automatic logic [7:0] reg_reset_val(input int unsigned idx);
    case (idx)
      RIDX_C:  return 8'h13;
      RIDX_E:  return 8'hD8;
      RIDX_H:  return 8'h01;
      RIDX_L:  return 8'h4D;
      RIDX_F:  return 8'hB0;
      RIDX_A:  return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cpu_seq_decode.sv
module cpu_seq_decode
  import cpu_seq_pkg::*;
(
  input  logic [7:0] opcode,
  output op_info_t   info
);
  logic [1:0] cc_field;
  assign cc_field = opcode[4:3];

  function automatic cond_e map_cc(input logic [1:0] f);
    case (f)
      2'b00:   return CC_NZ;
      2'b01:   return CC_Z;
      2'b10:   return CC_NC;
      default: return CC_C;
    endcase
  endfunction

  always_comb begin
    info.cls = OPC_BAD;
    info.cc  = CC_ALWAYS;
    info.dst = opcode[5:3];
    if (opcode == 8'h00) begin
      info.cls = OPC_NOP;
    end else if (opcode == 8'hC3) begin
      info.cls = OPC_JP;
    end else if (opcode[7:5] == 3'b110 && opcode[2:0] == 3'b010) begin
      info.cls = OPC_JP;
      info.cc  = map_cc(cc_field);
    end else if (opcode == 8'h18) begin
      info.cls = OPC_JR;
    end else if (opcode[7:5] == 3'b001 && opcode[2:0] == 3'b000) begin
      info.cls = OPC_JR;
      info.cc  = map_cc(cc_field);
    end else if (opcode[7:6] == 2'b00 && opcode[2:0] == 3'b110 && opcode[5:3] != 3'b110) begin
      info.cls = OPC_LDI;
    end else if (opcode == 8'hFA) begin
      info.cls = OPC_LDA;
    end else if (opcode == 8'hEA) begin
      info.cls = OPC_STA;
    end
  end
endmodule

// File: rtl/cpu_seq_regfile.sv
module cpu_seq_regfile
  import cpu_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NREG   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(NREG)-1:0]       widx,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NREG-1:0][DATA_W-1:0]   q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bit WRITABLE = (i != RIDX_F);
    localparam logic [DATA_W-1:0] RST = DATA_W'(reg_reset_val(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= RST;
      end else if (WRITABLE && we && widx == ($clog2(NREG))'(i)) begin
        q[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/cpu_seq_ctrl.sv
module cpu_seq_ctrl
  import cpu_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 8,
  parameter logic [15:0] RESET_PC      = 16'h0100,
  parameter logic [15:0] RESET_SP      = 16'hFFFE,
  parameter int unsigned TAKEN_PENALTY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  input  op_info_t          dec_info,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] opcode_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              reg_we,
  output logic [2:0]        reg_widx,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic              fetching,
  output logic              illegal
);
  localparam int unsigned PEN_W = $clog2(TAKEN_PENALTY + 1);
  localparam int unsigned EXT_W = ADDR_W - DATA_W;

  seq_state_e        st;
  op_info_t          info_q;
  logic [1:0]        step;
  logic              cond_q;
  logic [ADDR_W-1:0] idx;
  logic [DATA_W-1:0] bus_q;
  logic [PEN_W-1:0]  pen_cnt;
  logic              cond_ok;

  assign opcode_q = bus_q;

  always_comb begin
    case (dec_info.cc)
      CC_NZ:   cond_ok = !flag_z;
      CC_Z:    cond_ok = flag_z;
      CC_NC:   cond_ok = !flag_c;
      CC_C:    cond_ok = flag_c;
      default: cond_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_FETCH;
      pc      <= ADDR_W'(RESET_PC);
      sp      <= ADDR_W'(RESET_SP);
      idx     <= '0;
      bus_q   <= '0;
      info_q  <= '{cls: OPC_NOP, cc: CC_ALWAYS, dst: 3'd0};
      step    <= '0;
      cond_q  <= 1'b0;
      pen_cnt <= '0;
    end else begin
      case (st)
        ST_FETCH: begin
          bus_q <= mem_rdata;
          st    <= ST_DECODE;
        end
        ST_DECODE: begin
          info_q <= dec_info;
          cond_q <= cond_ok;
          pc     <= pc + 1'b1;
          step   <= '0;
          st     <= ST_STALL;
        end
        ST_STALL: st <= ST_EXEC;
        ST_EXEC: begin
          step <= step + 1'b1;
          st   <= ST_FETCH;
          case (info_q.cls)
            OPC_LDI: if (step == 2'd0) st <= ST_RDPC;
            OPC_JR: begin
              if (step == 2'd0) begin
                st <= ST_RDPC;
              end else if (cond_q) begin
                pc      <= pc + {{EXT_W{bus_q[DATA_W-1]}}, bus_q};
                pen_cnt <= '0;
                st      <= ST_PENALTY;
              end
            end
            OPC_JP: begin
              if (step == 2'd0) begin
                st <= ST_RDPC;
              end else if (step == 2'd1) begin
                idx[DATA_W-1:0] <= bus_q;
                st              <= ST_RDPC;
              end else if (cond_q) begin
                pc      <= {bus_q, idx[DATA_W-1:0]};
                pen_cnt <= '0;
                st      <= ST_PENALTY;
              end
            end
            OPC_LDA, OPC_STA: begin
              if (step == 2'd0) begin
                st <= ST_RDPC;
              end else if (step == 2'd1) begin
                idx[DATA_W-1:0] <= bus_q;
                st              <= ST_RDPC;
              end else if (step == 2'd2) begin
                idx[ADDR_W-1:DATA_W] <= bus_q;
                if (info_q.cls == OPC_STA) begin
                  bus_q <= acc;
                  st    <= ST_MOVE_ST;
                end else begin
                  st <= ST_MOVE_LD;
                end
              end
            end
            default: st <= ST_FETCH;
          endcase
        end
        ST_RDPC: begin
          bus_q <= mem_rdata;
          pc    <= pc + 1'b1;
          st    <= ST_RDPC_STALL;
        end
        ST_RDPC_STALL: st <= ST_STALL;
        ST_MOVE_LD:    st <= ST_MEM_LD;
        ST_MOVE_ST:    st <= ST_MEM_ST;
        ST_MEM_LD: begin
          bus_q <= mem_rdata;
          st    <= ST_STALL;
        end
        ST_MEM_ST:     st <= ST_STALL;
        ST_PENALTY: begin
          if (pen_cnt == PEN_W'(TAKEN_PENALTY - 1)) st <= ST_FETCH;
          else pen_cnt <= pen_cnt + 1'b1;
        end
        default: st <= ST_FETCH;
      endcase
    end
  end

  always_comb begin
    mem_rd    = (st == ST_FETCH) || (st == ST_RDPC) || (st == ST_MEM_LD);
    mem_wr    = (st == ST_MEM_ST);
    mem_addr  = (st == ST_MEM_LD || st == ST_MEM_ST) ? idx : pc;
    mem_wdata = bus_q;
    fetching  = (st == ST_FETCH);
    illegal   = (st == ST_EXEC) && (info_q.cls == OPC_BAD);
    reg_we    = (st == ST_EXEC) &&
                ((info_q.cls == OPC_LDI && step == 2'd1) ||
                 (info_q.cls == OPC_LDA && step == 2'd3));
    reg_widx  = (info_q.cls == OPC_LDI) ? info_q.dst : 3'(RIDX_A);
    reg_wdata = bus_q;
  end

  assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH) |=> (st == ST_DECODE));
  assert_decode_bumps_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DECODE) |=> (pc == $past(pc) + 1'b1) && (st == ST_STALL));
  assert_rdpc_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RDPC) |=> (st == ST_RDPC_STALL) && (pc == $past(pc) + 1'b1));
  assert_setup_before_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MOVE_LD) |=> mem_rd && (mem_addr == $past(idx)));
  assert_write_after_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(st) == ST_MOVE_ST) && !$past(mem_wr));
  assert_port_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_illegal_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal && fetching);
endmodule

// File: rtl/cpu_seq_top.sv
module cpu_seq_top
  import cpu_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CNT_W         = 32,
  parameter logic [15:0] RESET_PC      = 16'h0100,
  parameter logic [15:0] RESET_SP      = 16'hFFFE,
  parameter int unsigned TAKEN_PENALTY = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                op_fetch,
  output logic                illegal_op,
  output logic [ADDR_W-1:0]   pc_o,
  output logic [ADDR_W-1:0]   sp_o,
  output logic [2*DATA_W-1:0] reg_af,
  output logic [2*DATA_W-1:0] reg_bc,
  output logic [2*DATA_W-1:0] reg_de,
  output logic [2*DATA_W-1:0] reg_hl,
  output logic [CNT_W-1:0]    cycle_cnt
);
  localparam int unsigned NREG = 8;

  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]           opcode_q;
  op_info_t                    dec_info;
  logic                        reg_we;
  logic [2:0]                  reg_widx;
  logic [DATA_W-1:0]           reg_wdata;

  cpu_seq_decode u_decode (
    .opcode (opcode_q[7:0]),
    .info   (dec_info)
  );

  cpu_seq_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .widx  (reg_widx),
    .wdata (reg_wdata),
    .q     (regs)
  );

  cpu_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_PC(RESET_PC),
    .RESET_SP(RESET_SP), .TAKEN_PENALTY(TAKEN_PENALTY)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (mem_rdata),
    .dec_info  (dec_info),
    .flag_z    (regs[RIDX_F][FLAG_Z_BIT]),
    .flag_c    (regs[RIDX_F][FLAG_C_BIT]),
    .acc       (regs[RIDX_A]),
    .opcode_q  (opcode_q),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .reg_we    (reg_we),
    .reg_widx  (reg_widx),
    .reg_wdata (reg_wdata),
    .pc        (pc_o),
    .sp        (sp_o),
    .fetching  (op_fetch),
    .illegal   (illegal_op)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cycle_cnt <= '0;
    else        cycle_cnt <= cycle_cnt + 1'b1;
  end

  assign reg_af = {regs[RIDX_A], regs[RIDX_F]};
  assign reg_bc = {regs[RIDX_B], regs[RIDX_C]};
  assign reg_de = {regs[RIDX_D], regs[RIDX_E]};
  assign reg_hl = {regs[RIDX_H], regs[RIDX_L]};
endmodule

// File: tb/cpu_seq_top_tb_top.sv
module cpu_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        op_fetch, illegal_op;
  logic [15:0] pc_o, sp_o, reg_af, reg_bc, reg_de, reg_hl;
  logic [31:0] cycle_cnt;

  logic [7:0] mem [0:2047];
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr[10:0]];

  cpu_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .op_fetch(op_fetch), .illegal_op(illegal_op), .pc_o(pc_o), .sp_o(sp_o),
    .reg_af(reg_af), .reg_bc(reg_bc), .reg_de(reg_de), .reg_hl(reg_hl),
    .cycle_cnt(cycle_cnt)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_and_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
  endtask

  // runs one instruction from a fetch phase to the next fetch phase
  task automatic run_instr(output int cyc, output int nill, output int nwr,
                           output int nboth, output logic [15:0] waddr,
                           output logic [7:0] wdat);
    logic [31:0] c0;
    c0 = cycle_cnt; cyc = 0; nill = 0; nwr = 0; nboth = 0; waddr = '0; wdat = '0;
    forever begin
      if (illegal_op) nill++;
      if (mem_rd && mem_wr) nboth++;
      if (mem_wr) begin nwr++; waddr = mem_addr; wdat = mem_wdata; end
      @(negedge clk);
      cyc++;
      if (op_fetch || cyc >= 100) break;
    end
    chk("R10", "counter delta", cycle_cnt - c0, cyc);
    chk("R11", "rd/wr overlap", nboth, 0);
  endtask

  task automatic step_chk(input string req, input int exp_cyc, input logic [15:0] exp_pc);
    int cyc, nill, nwr, nboth;
    logic [15:0] wa;
    logic [7:0]  wd;
    run_instr(cyc, nill, nwr, nboth, wa, wd);
    chk(req, "cycles", cyc, exp_cyc);
    chk(req, "pc", {16'h0, pc_o}, {16'h0, exp_pc});
    chk("R9", "no illegal pulse", nill, 0);
  endtask

  task automatic t_reset();
    clear_and_reset();
    release_reset();
    chk("R1", "af", reg_af, 16'h01B0);
    chk("R1", "bc", reg_bc, 16'h0013);
    chk("R1", "de", reg_de, 16'h00D8);
    chk("R1", "hl", reg_hl, 16'h014D);
    chk("R1", "sp", sp_o, 16'hFFFE);
    chk("R1", "pc", pc_o, 16'h0100);
    chk("R1", "cycle", cycle_cnt, 0);
    chk("R1", "fetch first", {op_fetch, mem_rd}, 2'b11);
    chk("R11", "fetch addr", mem_addr, 16'h0100);
  endtask

  task automatic t_nop();
    clear_and_reset();
    release_reset();
    step_chk("R2", 4, 16'h0101);
    step_chk("R2", 4, 16'h0102);
    chk("R10", "counter after two nops", cycle_cnt, 8);
  endtask

  task automatic t_load_imm();
    logic [7:0] ops [7] = '{8'h06, 8'h0E, 8'h16, 8'h1E, 8'h26, 8'h2E, 8'h3E};
    logic [7:0] dat [7] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE};
    clear_and_reset();
    for (int i = 0; i < 7; i++) begin
      mem[11'h100 + 2*i]     = ops[i];
      mem[11'h100 + 2*i + 1] = dat[i];
    end
    release_reset();
    for (int i = 0; i < 7; i++) step_chk("R3", 8, 16'(16'h0102 + 2*i));
    chk("R3", "bc", reg_bc, 16'h1234);
    chk("R3", "de", reg_de, 16'h5678);
    chk("R3", "hl", reg_hl, 16'h9ABC);
    chk("R3", "af", reg_af, 16'hDEB0);
  endtask

  task automatic t_abs_jump();
    clear_and_reset();
    mem[11'h100] = 8'hC2; mem[11'h101] = 8'h00; mem[11'h102] = 8'h02;
    mem[11'h103] = 8'hD2; mem[11'h104] = 8'h00; mem[11'h105] = 8'h02;
    mem[11'h106] = 8'hCA; mem[11'h107] = 8'h00; mem[11'h108] = 8'h02;
    mem[11'h200] = 8'hDA; mem[11'h201] = 8'h10; mem[11'h202] = 8'h03;
    mem[11'h310] = 8'hC3; mem[11'h311] = 8'h34; mem[11'h312] = 8'h01;
    release_reset();
    step_chk("R4 R6 nz not taken", 12, 16'h0103);
    step_chk("R4 R6 nc not taken", 12, 16'h0106);
    step_chk("R4 R6 z taken", 16, 16'h0200);
    step_chk("R4 R6 c taken", 16, 16'h0310);
    step_chk("R4 always", 16, 16'h0134);
  endtask

  task automatic t_rel_jump();
    clear_and_reset();
    mem[11'h100] = 8'h18; mem[11'h101] = 8'h10;
    mem[11'h112] = 8'h20; mem[11'h113] = 8'h05;
    mem[11'h114] = 8'h30; mem[11'h115] = 8'h05;
    mem[11'h116] = 8'h28; mem[11'h117] = 8'hFE;
    mem[11'h116] = 8'h38; mem[11'h117] = 8'h80;
    release_reset();
    step_chk("R5 always", 12, 16'h0112);
    step_chk("R5 R6 nz not taken", 8, 16'h0114);
    step_chk("R5 R6 nc not taken", 8, 16'h0116);
    step_chk("R5 R6 c taken back 128", 12, 16'h0098);
  endtask

  task automatic t_mem();
    int cyc, nill, nwr, nboth;
    logic [15:0] wa;
    logic [7:0]  wd;
    clear_and_reset();
    mem[11'h100] = 8'h3E; mem[11'h101] = 8'h5A;
    mem[11'h102] = 8'hEA; mem[11'h103] = 8'h05; mem[11'h104] = 8'hC7;
    mem[11'h105] = 8'hFA; mem[11'h106] = 8'h20; mem[11'h107] = 8'h07;
    mem[11'h720] = 8'hA5;
    release_reset();
    step_chk("R3", 8, 16'h0102);
    run_instr(cyc, nill, nwr, nboth, wa, wd);
    chk("R8", "store cycles", cyc, 16);
    chk("R8", "store count", nwr, 1);
    chk("R8", "store addr", wa, 16'hC705);
    chk("R8", "store data", wd, 8'h5A);
    chk("R8", "pc", pc_o, 16'h0105);
    run_instr(cyc, nill, nwr, nboth, wa, wd);
    chk("R7", "load cycles", cyc, 16);
    chk("R7", "load no write", nwr, 0);
    chk("R7", "acc", reg_af, 16'hA5B0);
    chk("R7", "pc", pc_o, 16'h0108);
  endtask

  task automatic t_illegal();
    int cyc, nill, nwr, nboth;
    logic [15:0] wa;
    logic [7:0]  wd;
    clear_and_reset();
    mem[11'h100] = 8'hD3;
    mem[11'h101] = 8'h36;
    release_reset();
    run_instr(cyc, nill, nwr, nboth, wa, wd);
    chk("R9", "cycles", cyc, 4);
    chk("R9", "pulse count", nill, 1);
    chk("R9", "pc", pc_o, 16'h0101);
    run_instr(cyc, nill, nwr, nboth, wa, wd);
    chk("R9", "ld-hl form pulse", nill, 1);
    chk("R9", "regs kept", {reg_af, reg_bc}, 32'h01B0_0013);
    chk("R9", "regs kept", {reg_de, reg_hl}, 32'h00D8_014D);
    step_chk("R9 nop after", 4, 16'h0103);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_nop();
    t_load_imm();
    t_abs_jump();
    t_rel_jump();
    t_mem();
    t_illegal();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule